// File: doc/BRIEF.md
# Multithreaded Retire Slot Thread Picker

This block decides which hardware thread may retire the oldest entry of its reorder buffer in a given retire slot. For every thread it takes a three-bit state code, a flag saying the oldest entry is ready, a flag saying the buffer is empty, and the sequence number of that oldest entry. It answers with a valid flag and a thread index. The answer is purely combinational, so the retire logic can consult it once per slot, several times in the same cycle.

Two selection rules are supported. The rotating rule keeps a priority order of threads in registers. It grants the first qualifying thread in that order, and that thread moves to the back of the order when the caller acknowledges the grant. The age rule grants the qualifying thread whose oldest entry has the smallest sequence number. A third, greedy setting uses the age rule. When the block is built for a single thread, it ignores the policy and reports that thread whenever the thread's state permits retirement.

Top module: `smt_commit_picker`

## Requirements
- R1: A thread can be picked only when its state code is 0 (idle), 1 (running) or 2 (waiting on a fetch-side trap). Codes 3 (buffer squashing), 4 (trap waiting), 5 (squash-after waiting), 6 and 7 exclude it.
- R2: With more than one thread, a thread qualifies only when R1 holds, its ready flag is 1 and its empty flag is 0. Under the rotating policy (policy code 0), the first qualifying thread in the priority order is picked.
- R3: When grant_ack_i is 1 on a clock edge, with policy 0 and a valid pick, the picked thread moves to the last place of the priority order. The other threads keep their relative order. The order changes only on the clock edge.
- R4: After reset the priority order is thread 0, 1, ..., N-1.
- R5: Under policy code 1 (age rule), the qualifying thread with the smallest unsigned head sequence number is picked. On a tie, the lower thread index wins.
- R6: Policy codes 2 (greedy) and 3 pick exactly as policy code 1 does.
- R7: When no thread qualifies, sel_valid_o is 0 and sel_tid_o is 0.
- R8: An acknowledge under policy 1, 2 or 3, or an acknowledge with no valid pick, leaves the priority order unchanged.
- R9: With NUM_THR equal to 1, sel_valid_o equals the R1 state test on thread 0, whatever the ready flag, the empty flag and the policy are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| policy_i | input | 2 | 0 rotating, 1 age rule, 2 greedy, 3 same as 1 |
| thr_state_i | input | 3*NUM_THR | Per-thread state code, thread t in bits [3t+2:3t] |
| head_rdy_i | input | NUM_THR | Oldest entry of the thread is ready to retire |
| rob_empty_i | input | NUM_THR | Thread's reorder buffer holds nothing |
| head_seq_i | input | SEQ_W*NUM_THR | Head sequence number, thread t in bits [SEQ_W*t +: SEQ_W] |
| grant_ack_i | input | 1 | The current pick was used; advance the rotating order |
| sel_valid_o | output | 1 | A thread was picked |
| sel_tid_o | output | TID_W | Picked thread index |

## Verification
The hardest state to reach from the ports is a priority order that has been scrambled by a long run of acknowledges, while only a few threads qualify, so that the rule "first in the order" differs from "lowest index". The stimulus drives hundreds of random cycles. In each cycle it draws the policy, the state codes, the flags and small sequence numbers that often collide, and it acknowledges about half of the valid picks. A bench-side copy of the order tracks each rotation. Directed steps add equal sequence numbers, acknowledges that must not rotate the order, and a single-thread build.

// File: rtl/cp_pkg.sv
package cp_pkg;

   localparam int STATE_W = 3;

   typedef enum logic [STATE_W-1:0] {
      ST_IDLE       = 3'd0,
      ST_RUN        = 3'd1,
      ST_FETCH_TRAP = 3'd2,
      ST_ROB_SQUASH = 3'd3,
      ST_TRAP_WAIT  = 3'd4,
      ST_SQ_AFTER   = 3'd5
   } thr_state_e;

   typedef enum logic [1:0] {
      POL_ROTATE = 2'd0,
      POL_AGE    = 2'd1,
      POL_GREEDY = 2'd2
   } pick_pol_e;

   function automatic logic state_can_retire(logic [STATE_W-1:0] s);
      return (s == ST_IDLE) || (s == ST_RUN) || (s == ST_FETCH_TRAP);
   endfunction

endpackage

// File: rtl/cp_qualify.sv
module cp_qualify #(
   parameter int N = 4
) (
   input  logic [cp_pkg::STATE_W*N-1:0] state_i,
   input  logic [N-1:0]                 rdy_i,
   input  logic [N-1:0]                 empty_i,
   output logic [N-1:0]                 qual_o
);
   localparam int SW = cp_pkg::STATE_W;

   for (genvar t = 0; t < N; t++) begin : g_thr
      assign qual_o[t] = cp_pkg::state_can_retire(state_i[t*SW +: SW])
                         && rdy_i[t] && !empty_i[t];
   end
endmodule

// File: rtl/cp_rr_order.sv
module cp_rr_order #(
   parameter int N     = 4,
   parameter int TID_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N-1:0]     qual_i,
   input  logic             adv_i,
   output logic             hit_o,
   output logic [TID_W-1:0] tid_o,
   output logic [TID_W*N-1:0] order_o
);
   logic [TID_W-1:0] order_q [N];
   logic [TID_W-1:0] pos;

   always_comb begin
      hit_o = 1'b0;
      tid_o = '0;
      pos   = '0;
      for (int p = N - 1; p >= 0; p--) begin
         if (qual_i[order_q[p]]) begin
            hit_o = 1'b1;
            tid_o = order_q[p];
            pos   = TID_W'(p);
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int p = 0; p < N; p++) order_q[p] <= TID_W'(p);
      end else if (adv_i && hit_o) begin
         for (int p = 0; p < N - 1; p++) begin
            if (p >= int'(pos)) order_q[p] <= order_q[p+1];
         end
         order_q[N-1] <= tid_o;
      end
   end

   for (genvar p = 0; p < N; p++) begin : g_out
      assign order_o[p*TID_W +: TID_W] = order_q[p];
   end
endmodule

// File: rtl/cp_age_pick.sv
module cp_age_pick #(
   parameter int N     = 4,
   parameter int SEQ_W = 32,
   parameter int TID_W = 2
) (
   input  logic [N-1:0]       qual_i,
   input  logic [SEQ_W*N-1:0] seq_i,
   output logic               hit_o,
   output logic [TID_W-1:0]   tid_o
);
   logic [SEQ_W-1:0] best;

   always_comb begin
      hit_o = 1'b0;
      tid_o = '0;
      best  = '0;
      for (int t = 0; t < N; t++) begin
         if (qual_i[t] && (!hit_o || seq_i[t*SEQ_W +: SEQ_W] < best)) begin
            hit_o = 1'b1;
            tid_o = TID_W'(t);
            best  = seq_i[t*SEQ_W +: SEQ_W];
         end
      end
   end
endmodule

// File: rtl/smt_commit_picker.sv
module smt_commit_picker #(
   parameter int NUM_THR = 4,
   parameter int SEQ_W   = 32,
   localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
   localparam int SW     = cp_pkg::STATE_W
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic [1:0]               policy_i,
   input  logic [SW*NUM_THR-1:0]    thr_state_i,
   input  logic [NUM_THR-1:0]       head_rdy_i,
   input  logic [NUM_THR-1:0]       rob_empty_i,
   input  logic [SEQ_W*NUM_THR-1:0] head_seq_i,
   input  logic                     grant_ack_i,
   output logic                     sel_valid_o,
   output logic [TID_W-1:0]         sel_tid_o
);
   import cp_pkg::*;

   if (NUM_THR < 1) begin : g_bad_thr
      $error("NUM_THR must be at least 1");
   end
   if (SEQ_W < 1) begin : g_bad_seq
      $error("SEQ_W must be at least 1");
   end

   logic [TID_W*NUM_THR-1:0] rr_order_flat;

   if (NUM_THR == 1) begin : g_single
      assign sel_valid_o   = state_can_retire(thr_state_i[SW-1:0]);
      assign sel_tid_o     = '0;
      assign rr_order_flat = '0;
   end else begin : g_multi
      logic [NUM_THR-1:0] qual;
      logic               rr_hit, age_hit;
      logic [TID_W-1:0]   rr_tid, age_tid;
      logic               use_rr;

      assign use_rr = (policy_i == POL_ROTATE);

      cp_qualify #(.N(NUM_THR)) u_qual (
         .state_i (thr_state_i),
         .rdy_i   (head_rdy_i),
         .empty_i (rob_empty_i),
         .qual_o  (qual)
      );

      cp_rr_order #(.N(NUM_THR), .TID_W(TID_W)) u_rr (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .qual_i  (qual),
         .adv_i   (grant_ack_i && use_rr),
         .hit_o   (rr_hit),
         .tid_o   (rr_tid),
         .order_o (rr_order_flat)
      );

      cp_age_pick #(.N(NUM_THR), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_age (
         .qual_i (qual),
         .seq_i  (head_seq_i),
         .hit_o  (age_hit),
         .tid_o  (age_tid)
      );

      assign sel_valid_o = use_rr ? rr_hit : age_hit;
      assign sel_tid_o   = use_rr ? rr_tid : age_tid;
   end
endmodule

// File: rtl/cp_checker.sv
module cp_checker #(
   parameter int N     = 4,
   parameter int SEQ_W = 32,
   parameter int TID_W = 2
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic [1:0]           policy_i,
   input logic [3*N-1:0]       thr_state_i,
   input logic [N-1:0]         head_rdy_i,
   input logic [N-1:0]         rob_empty_i,
   input logic [SEQ_W*N-1:0]   head_seq_i,
   input logic                 grant_ack_i,
   input logic                 sel_valid_o,
   input logic [TID_W-1:0]     sel_tid_o,
   input logic [TID_W*N-1:0]   order_flat
);
   logic [2:0] sel_state;
   assign sel_state = thr_state_i[sel_tid_o*3 +: 3];

   // R1: a picked thread always has a permitting state code
   a_r1_state_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_valid_o |-> cp_pkg::state_can_retire(sel_state));

   if (N > 1) begin : g_multi
      logic [N-1:0] q;
      logic         older_exists;
      logic [N-1:0] used;
      logic [SEQ_W-1:0] sel_seq;

      assign sel_seq = head_seq_i[sel_tid_o*SEQ_W +: SEQ_W];

      always_comb begin
         older_exists = 1'b0;
         used = '0;
         for (int t = 0; t < N; t++) begin
            q[t] = cp_pkg::state_can_retire(thr_state_i[t*3 +: 3])
                   && head_rdy_i[t] && !rob_empty_i[t];
            if (q[t] && ((head_seq_i[t*SEQ_W +: SEQ_W] < sel_seq) ||
                 (head_seq_i[t*SEQ_W +: SEQ_W] == sel_seq && t < int'(sel_tid_o))))
               older_exists = 1'b1;
            used[order_flat[t*TID_W +: TID_W]] = 1'b1;
         end
      end

      // R2: a picked thread is ready and holds entries
      a_r2_ready_pick: assert property (@(posedge clk_i) disable iff (!rst_ni)
         sel_valid_o |-> (head_rdy_i[sel_tid_o] && !rob_empty_i[sel_tid_o]));

      // R7: nothing qualifies, nothing is picked
      a_r7_none_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (q == '0) |-> (!sel_valid_o && sel_tid_o == '0));

      // R5, R6: age rule never skips an older qualifying thread
      a_r5_oldest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (policy_i != 2'd0 && sel_valid_o) |-> !older_exists);

      // R4: the order always holds every thread exactly once
      a_r4_order_perm: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $countones(used) == N);

      // R8: without an acknowledged rotating pick the order stays put
      a_r8_order_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !(grant_ack_i && sel_valid_o && policy_i == 2'd0) |=> $stable(order_flat));

      // R3: an acknowledged rotating pick lands in the last place
      a_r3_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (grant_ack_i && sel_valid_o && policy_i == 2'd0) |=>
            order_flat[(N-1)*TID_W +: TID_W] == $past(sel_tid_o));
   end
endmodule

bind smt_commit_picker cp_checker #(.N(NUM_THR), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .policy_i    (policy_i),
   .thr_state_i (thr_state_i),
   .head_rdy_i  (head_rdy_i),
   .rob_empty_i (rob_empty_i),
   .head_seq_i  (head_seq_i),
   .grant_ack_i (grant_ack_i),
   .sel_valid_o (sel_valid_o),
   .sel_tid_o   (sel_tid_o),
   .order_flat  (rr_order_flat)
);

// File: tb/smt_commit_picker_bench.sv
module smt_commit_picker_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N = 4;
   localparam int SW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [1:0]      pol;
   logic [2:0]      st  [N];
   logic [N-1:0]    rdy, emp;
   logic [SW-1:0]   sq  [N];
   logic            ack;
   logic [3*N-1:0]  st_flat;
   logic [SW*N-1:0] sq_flat;
   logic            v;
   logic [1:0]      tid;

   logic [2:0]  s1_st;
   logic        s1_rdy, s1_emp, s1_v;
   logic        s1_tid;

   always_comb begin
      for (int t = 0; t < N; t++) begin
         st_flat[t*3 +: 3]   = st[t];
         sq_flat[t*SW +: SW] = sq[t];
      end
   end

   smt_commit_picker #(.NUM_THR(N), .SEQ_W(SW)) u_smt_commit_picker (
      .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .thr_state_i(st_flat),
      .head_rdy_i(rdy), .rob_empty_i(emp), .head_seq_i(sq_flat),
      .grant_ack_i(ack), .sel_valid_o(v), .sel_tid_o(tid));

   smt_commit_picker #(.NUM_THR(1), .SEQ_W(SW)) u_smt_commit_picker_one (
      .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .thr_state_i(s1_st),
      .head_rdy_i(s1_rdy), .rob_empty_i(s1_emp), .head_seq_i(32'd5),
      .grant_ack_i(ack), .sel_valid_o(s1_v), .sel_tid_o(s1_tid));

   int total = 0;
   int bad = 0;
   int m_order [N];

   function automatic logic can_go(logic [2:0] s);
      return s <= 3'd2;
   endfunction

   function automatic logic qual(int t);
      return can_go(st[t]) && rdy[t] && !emp[t];
   endfunction

   function automatic void model(output logic ev, output int et, output int epos);
      ev = 1'b0; et = 0; epos = 0;
      if (pol == 2'd0) begin
         for (int p = 0; p < N; p++)
            if (!ev && qual(m_order[p])) begin ev = 1'b1; et = m_order[p]; epos = p; end
      end else begin
         for (int t = 0; t < N; t++)
            if (qual(t) && (!ev || sq[t] < sq[et])) begin ev = 1'b1; et = t; end
      end
   endfunction

   task automatic check_pick(string req);
      logic ev; int et, epos;
      model(ev, et, epos);
      total++;
      if (v !== ev || tid !== 2'(et)) begin
         bad++;
         $display("FAIL %s: got valid=%0b tid=%0d expected valid=%0b tid=%0d",
                  req, v, tid, ev, et);
      end
   endtask

   task automatic step(string req);
      logic ev; int et, epos;
      #1;
      check_pick(req);
      model(ev, et, epos);
      if (ack && ev && pol == 2'd0) begin
         for (int p = epos; p < N - 1; p++) m_order[p] = m_order[p+1];
         m_order[N-1] = et;
      end
      @(negedge clk);
   endtask

   task automatic set_all(logic [2:0] s, logic r, logic e);
      for (int t = 0; t < N; t++) begin st[t] = s; sq[t] = 32'(t); end
      rdy = {N{r}}; emp = {N{e}};
   endtask

   task automatic check_one(logic exp, string req);
      #1;
      total++;
      if (s1_v !== exp || s1_tid !== 1'b0) begin
         bad++;
         $display("FAIL %s: got valid=%0b tid=%0d expected valid=%0b tid=0",
                  req, s1_v, s1_tid, exp);
      end
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD*100000);
      total++; bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240607));
      for (int p = 0; p < N; p++) m_order[p] = p;
      pol = 2'd0; ack = 1'b0; set_all(3'd0, 1'b1, 1'b0);
      s1_st = 3'd1; s1_rdy = 1'b0; s1_emp = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: reset order starts at thread 0
      step("R4 reset order");
      // R3: acknowledged picks rotate 0,1,2,3,0
      ack = 1'b1;
      for (int i = 0; i < 5; i++) step("R3 rotation");
      ack = 1'b0;
      // R1, R7: excluded states give no pick
      for (int c = 3; c < 8; c++) begin set_all(3'(c), 1'b1, 1'b0); step("R1 R7 excluded state"); end
      // R1: only thread 2 permitted, fetch-trap wait code
      set_all(3'd5, 1'b1, 1'b0); st[2] = 3'd2; step("R1 fetch-trap wait eligible");
      // R2: ready but empty thread is skipped
      set_all(3'd1, 1'b1, 1'b0); emp[1] = 1'b1; emp[2] = 1'b1; rdy[3] = 1'b0; step("R2 empty skipped");
      // R5, R6: age rule with ties
      set_all(3'd1, 1'b1, 1'b0); sq[0] = 40; sq[1] = 10; sq[2] = 30; sq[3] = 10;
      for (int pp = 1; pp < 4; pp++) begin pol = 2'(pp); step(pp == 1 ? "R5 age tie" : "R6 greedy as age"); end
      // R8: acknowledge under age rule does not rotate
      pol = 2'd1; ack = 1'b1; step("R8 ack under age");
      pol = 2'd0; ack = 1'b0; set_all(3'd0, 1'b1, 1'b0); step("R8 order kept after age ack");
      // R8: acknowledge with nothing picked
      set_all(3'd4, 1'b1, 1'b0); ack = 1'b1; step("R8 ack without pick");
      ack = 1'b0; set_all(3'd0, 1'b1, 1'b0); step("R8 order kept after empty ack");
      // R9: single-thread build ignores ready, empty and policy
      s1_st = 3'd1; s1_rdy = 1'b0; s1_emp = 1'b1; pol = 2'd1; check_one(1'b1, "R9 single eligible");
      s1_st = 3'd2; pol = 2'd0; check_one(1'b1, "R9 single fetch-trap");
      s1_st = 3'd3; s1_rdy = 1'b1; s1_emp = 1'b0; check_one(1'b0, "R9 single excluded");
      // random mix
      for (int i = 0; i < 600; i++) begin
         pol = 2'($urandom % 4);
         for (int t = 0; t < N; t++) begin
            st[t] = ($urandom % 3 == 0) ? 3'($urandom % 8) : 3'($urandom % 3);
            sq[t] = 32'($urandom % 8) + (($urandom % 5 == 0) ? 32'hFFFF_FFF0 : 32'd0);
         end
         rdy = 4'($urandom); emp = 4'($urandom) & 4'($urandom);
         ack = 1'($urandom);
         step(pol == 2'd0 ? "R2 R3 random rotate" : "R5 R6 random age");
      end
      ack = 1'b0;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule